// File: doc/BRIEF.md
# Memory Error Interrupt Capture

This unit sits beside a memory controller and records access faults of three kinds: an address that decodes to no memory, an access that lands on an invalid page of the translation table, and an access that breaks the security rules. The detectors that find these faults live elsewhere. Each one gives this unit a one-cycle pulse together with the requesting client, the access direction and the faulting address. The unit turns each pulse into a sticky status bit. It also freezes a description of the first fault of each kind until software acknowledges it.

Software reaches the unit through a small word-addressed register port. The port holds a status word, an enable mask, and one capture/address register pair per fault kind. In each pair the address word sits four bytes above its capture word. A single interrupt line is raised while any pending fault is also enabled in the mask. Software reads the capture pair, then writes ones to the status word to acknowledge the fault.

Top module: `mem_err_irq`

## Requirements
- R1: After reset the status word, mask, every capture word, every address word and `irq` all read as zero.
- R2: A pulse on a fault input sets its status bit on the next clock edge. Decode faults use status bit 0, invalid-page faults use bit 1 and security faults use bit 2.
- R3: The decode capture word holds the client ID in bits [5:0] and the write flag in bit 31. All other bits are zero.
- R4: The invalid-page capture word holds the write flag in bit 0 and the client ID in bits [6:1]. All other bits are zero.
- R5: The security capture word holds the client ID in bits [5:0], the violation kind in bit 30 and the write flag in bit 31. All other bits are zero.
- R6: Register offsets are: status at 0x00, mask at 0x04, decode capture/address at 0x08/0x0C, invalid-page at 0x10/0x14 and security at 0x18/0x1C. Each address word holds the full 32-bit faulting address.
- R7: A write to the status offset clears each status bit whose data bit is one. Bits written as zero keep their value.
- R8: `irq` is high exactly when some status bit is set whose matching mask bit (mask bits [2:0] at offset 0x04) is also set.
- R9: While a status bit is set, later faults of that kind leave its capture and address words unchanged.
- R10: Faults of different kinds in the same cycle each set their own status bit and fill their own capture pair.
- R11: If a fault arrives in the same cycle that software clears its status bit, the bit stays set and the capture pair takes the new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_err | input | 1 | Address decode fault pulse |
| dec_cid | input | 6 | Client ID of the decode fault |
| dec_wr | input | 1 | Decode fault was a write |
| dec_addr | input | 32 | Decode fault address |
| pg_err | input | 1 | Invalid-page fault pulse |
| pg_cid | input | 6 | Client ID of the invalid-page fault |
| pg_wr | input | 1 | Invalid-page fault was a write |
| pg_addr | input | 32 | Invalid-page fault address |
| sec_err | input | 1 | Security fault pulse |
| sec_cid | input | 6 | Client ID of the security fault |
| sec_wr | input | 1 | Security fault was a write |
| sec_kind | input | 1 | Security violation kind |
| sec_addr | input | 32 | Security fault address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The critical coincidence is a fault pulse and a write-one-to-clear of the same status bit landing on one clock edge. The bench provokes it by first raising the invalid-page bit with one fault. It then drives a second fault with different client, direction and address in the very cycle it writes the clearing one. It judges the result by reading back a still-set status bit and a capture pair that now describes the second fault. It also drives a repeat fault while the bit is still pending, and expects that fault to leave the capture pair unchanged.

// File: rtl/mem_err_irq.sv
module mem_err_irq #(
  parameter int CID_W = 6,
  parameter int RA_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_err,
  input  logic [CID_W-1:0] dec_cid,
  input  logic             dec_wr,
  input  logic [31:0]      dec_addr,
  input  logic             pg_err,
  input  logic [CID_W-1:0] pg_cid,
  input  logic             pg_wr,
  input  logic [31:0]      pg_addr,
  input  logic             sec_err,
  input  logic [CID_W-1:0] sec_cid,
  input  logic             sec_wr,
  input  logic             sec_kind,
  input  logic [31:0]      sec_addr,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq
);
  localparam logic [RA_W-1:0] OFS_STAT = RA_W'(8'h00);
  localparam logic [RA_W-1:0] OFS_MASK = RA_W'(8'h04);
  localparam logic [RA_W-1:0] OFS_DEC  = RA_W'(8'h08);
  localparam logic [RA_W-1:0] OFS_PG   = RA_W'(8'h10);
  localparam logic [RA_W-1:0] OFS_SEC  = RA_W'(8'h18);

  logic [2:0]       stat_q, mask_q;
  logic [2:0][31:0] cap_q, adr_q;
  logic [2:0][31:0] cw, aw;

  wire       stat_wr = reg_we && (reg_addr == OFS_STAT);
  wire [2:0] clr     = stat_wr ? reg_wdata[2:0] : 3'b000;
  wire [2:0] hit     = {sec_err, pg_err, dec_err};
  wire [2:0] take    = hit & (~stat_q | clr);

  always_comb begin
    cw = '0;
    cw[0][CID_W-1:0] = dec_cid;
    cw[0][31]        = dec_wr;
    cw[1][0]         = pg_wr;
    cw[1][CID_W:1]   = pg_cid;
    cw[2][CID_W-1:0] = sec_cid;
    cw[2][30]        = sec_kind;
    cw[2][31]        = sec_wr;
    aw = {sec_addr, pg_addr, dec_addr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      cap_q  <= '0;
      adr_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      if (reg_we && reg_addr == OFS_MASK) mask_q <= reg_wdata[2:0];
      for (int i = 0; i < 3; i++) begin
        if (take[i]) begin
          cap_q[i] <= cw[i];
          adr_q[i] <= aw[i];
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:                 reg_rdata = {29'd0, stat_q};
      OFS_MASK:                 reg_rdata = {29'd0, mask_q};
      OFS_DEC:                  reg_rdata = cap_q[0];
      OFS_DEC + RA_W'(4):       reg_rdata = adr_q[0];
      OFS_PG:                   reg_rdata = cap_q[1];
      OFS_PG + RA_W'(4):        reg_rdata = adr_q[1];
      OFS_SEC:                  reg_rdata = cap_q[2];
      OFS_SEC + RA_W'(4):       reg_rdata = adr_q[2];
      default:                  reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/mem_err_irq_chk.sv
module mem_err_irq_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       hit,
  input logic [2:0]       clr,
  input logic [2:0]       stat_q,
  input logic [2:0]       mask_q,
  input logic [2:0][31:0] cap_q,
  input logic             irq
);
  // R2
  a_r2_dec_set: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> stat_q[0]);
  // R2
  a_r2_sec_set: assert property (@(posedge clk) disable iff (!rst_n) hit[2] |=> stat_q[2]);
  // R7
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n) (clr[0] && !hit[0]) |=> !stat_q[0]);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n) (stat_q[1] && !clr[1]) |=> $stable(cap_q[1]));
  // R11
  a_r11_clash: assert property (@(posedge clk) disable iff (!rst_n) (clr[1] && hit[1]) |=> stat_q[1]);
  // R8
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == 3'b000) |-> !irq);
endmodule

bind mem_err_irq mem_err_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr),
  .stat_q(stat_q), .mask_q(mask_q), .cap_q(cap_q), .irq(irq)
);

// File: tb/mem_err_irq_bench.sv
module mem_err_irq_bench;
  logic clk = 0, rst_n = 0;
  logic dec_err = 0, dec_wr = 0, pg_err = 0, pg_wr = 0, sec_err = 0, sec_wr = 0, sec_kind = 0;
  logic [5:0] dec_cid = 0, pg_cid = 0, sec_cid = 0;
  logic [31:0] dec_addr = 0, pg_addr = 0, sec_addr = 0;
  logic reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  mem_err_irq u_mem_err_irq (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    dec_err = 0; pg_err = 0; sec_err = 0; reg_we = 0;
  endtask

  task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ec, ea;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 32; a += 4) rd("R1", 6'(a), 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2..R7 sweep over every class, client and direction
    for (int c = 0; c < 3; c++)
      for (int id = 0; id < 64; id++)
        for (int w = 0; w < 2; w++) begin
          ea = 32'hA000_0000 ^ (32'(id) * 32'h0101_0101) ^ (32'(c) << 28) ^ 32'(w);
          case (c)
            0: begin dec_err = 1; dec_cid = 6'(id); dec_wr = w[0]; dec_addr = ea;
                     ec = {w[0], 25'd0, 6'(id)}; end
            1: begin pg_err = 1; pg_cid = 6'(id); pg_wr = w[0]; pg_addr = ea;
                     ec = {25'd0, 6'(id), w[0]}; end
            default: begin sec_err = 1; sec_cid = 6'(id); sec_wr = w[0];
                     sec_kind = id[0] ^ w[0]; sec_addr = ea;
                     ec = {w[0], id[0] ^ w[0], 24'd0, 6'(id)}; end
          endcase
          cyc();
          rd("R2", 6'h00, 32'(1) << c);
          rd(c == 0 ? "R3" : c == 1 ? "R4" : "R5", 6'(8 + 8 * c), ec);
          rd("R6", 6'(12 + 8 * c), ea);
          wr(6'h00, 32'(1) << c);
          rd("R7", 6'h00, 0);
        end

    // R7 writing zeros keeps bits; R9 later fault does not overwrite
    dec_err = 1; dec_cid = 5; dec_wr = 0; dec_addr = 32'h1111_0000; cyc();
    wr(6'h00, 32'hFFFF_FFF8);
    rd("R7 zeros keep", 6'h00, 32'h1);
    dec_err = 1; dec_cid = 9; dec_wr = 1; dec_addr = 32'h2222_0000; cyc();
    rd("R9 cap", 6'h08, 32'd5);
    rd("R9 addr", 6'h0C, 32'h1111_0000);
    wr(6'h00, 32'h7);

    // R10 simultaneous faults
    dec_err = 1; dec_cid = 1; dec_wr = 1; dec_addr = 32'hD000_0001;
    pg_err = 1; pg_cid = 2; pg_wr = 0; pg_addr = 32'hD000_0002;
    sec_err = 1; sec_cid = 3; sec_wr = 0; sec_kind = 1; sec_addr = 32'hD000_0003;
    cyc();
    rd("R10 stat", 6'h00, 32'h7);
    rd("R10 dec", 6'h08, 32'h8000_0001);
    rd("R10 pg", 6'h10, 32'h0000_0004);
    rd("R10 sec", 6'h18, 32'h4000_0003);
    rd("R10 sec addr", 6'h1C, 32'hD000_0003);
    wr(6'h00, 32'h7);

    // R11 clear and new fault in the same cycle
    pg_err = 1; pg_cid = 7; pg_wr = 0; pg_addr = 32'h0000_7000; cyc();
    pg_err = 1; pg_cid = 40; pg_wr = 1; pg_addr = 32'h0000_4000;
    wr(6'h00, 32'h2);
    rd("R11 stat", 6'h00, 32'h2);
    rd("R11 cap", 6'h10, {25'd0, 6'd40, 1'b1});
    rd("R11 addr", 6'h14, 32'h0000_4000);
    wr(6'h00, 32'h7);

    // R8 mask sweep
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++) begin
        wr(6'h04, 32'(m));
        dec_err = p[0]; pg_err = p[1]; sec_err = p[2]; cyc();
        chk("R8 irq", {31'd0, irq}, {31'd0, |(p[2:0] & m[2:0])});
        rd("R8 mask", 6'h04, 32'(m));
        wr(6'h00, 32'h7);
      end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule